// File: doc/BRIEF.md
# Reassembly Time-Out Scanner

This block watches a set of virtual channels for reassembly that has stalled partway through a packet. Each channel has a small table entry: a time-out enable, a mode (message or streaming), a terminal count, an "open packet" flag, an idle count and two buffer pointers. The first is the pointer of the first cell of the open packet. The second is the pointer of the latest cell. Each arriving cell clears its channel's idle count and records its pointer.

A shared prescaler divides the clock by a programmable value. Each prescaler tick moves a round-robin scan pointer on by one position, and the channel under the pointer has its idle count raised by one. Only channels that are enabled, open and have a non-zero terminal count take part. The idle count needed for a time-out is the channel's terminal count, so the time-out interval is roughly prescale × scan length × terminal count clock cycles. When a channel reaches its terminal count, the block raises a status entry on a valid/ready output. The scan freezes until the entry is taken. Once the entry is accepted, the channel is closed so that its next cell starts a new packet.

Top module: `rto_scanner`

## Requirements
- R1: A tick occurs once every `pre_per` clock cycles. With `pre_per` equal to 0 there are no ticks, so no idle count moves and no time-out is raised.
- R2: Each tick visits one scan position, in ascending order, and wraps to position 0 after position `scan_len`-1. After the last cell of a channel, its time-out entry is raised no sooner than (term-1)·pre_per·scan_len cycles and no later than term·pre_per·scan_len cycles, plus a few cycles of pipeline delay.
- R3: A cell on a channel clears that channel's idle count. When no packet is open, the cell opens one and records its pointer as the first pointer. Every cell records its pointer as the last pointer. A channel that keeps receiving cells within its time-out interval never times out.
- R4: A channel is skipped by the scan when it is disabled, when it has no open packet, or when its terminal count is 0. A skipped channel produces no entry and its idle count does not change.
- R5: A time-out entry carries `stat_code` = 4'b0001 (bit 0 is the time-out flag; the other bits are 0) and the channel index in `stat_idx`. `stat_ptr` holds the first pointer when the mode is 0 (message) and the last pointer when the mode is 1 (streaming).
- R6: While `stat_vld` is high and `stat_ready` is low, the entry stays unchanged, the scan pointer does not move, and no idle count advances. Every entry raised is eventually delivered exactly once.
- R7: When an entry is accepted, the channel's open flag and idle count return to 0. The next cell on that channel starts a new packet.
- R8: A table write sets the channel's enable, mode and terminal count, which are readable on the read port. The same write clears the channel's open flag and idle count.
- R9: After reset, `stat_vld` is low and every table field reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pre_per | input | PRE_W | Prescale divider, 0 stops the scan |
| scan_len | input | SCAN_W | Number of scan positions per round |
| cfg_we | input | 1 | Table write strobe |
| cfg_idx | input | CH_W | Channel written |
| cfg_en | input | 1 | Time-out enable to write |
| cfg_mode | input | 1 | 0 message, 1 streaming |
| cfg_term | input | TERM_W | Terminal idle count to write |
| rd_idx | input | CH_W | Channel read |
| rd_en | output | 1 | Enable of read channel |
| rd_mode | output | 1 | Mode of read channel |
| rd_term | output | TERM_W | Terminal count of read channel |
| rd_open | output | 1 | Open-packet flag of read channel |
| rd_idle | output | TERM_W | Idle count of read channel |
| rd_first | output | PTR_W | First pointer of read channel |
| rd_last | output | PTR_W | Last pointer of read channel |
| cell_vld | input | 1 | Cell arrival strobe |
| cell_idx | input | CH_W | Channel of the arriving cell |
| cell_ptr | input | PTR_W | Buffer pointer of the arriving cell |
| stat_vld | output | 1 | Time-out entry valid |
| stat_ready | input | 1 | Consumer accepts the entry |
| stat_code | output | 4 | Status field, bit 0 is the time-out flag |
| stat_idx | output | CH_W | Channel that timed out |
| stat_ptr | output | PTR_W | Buffer pointer for the entry |

## Verification
The in-RTL assertions check several things on every cycle:
- the prescaler never ticks twice in a row when the divider is above one;
- the scan pointer is frozen while an entry waits;
- a waiting entry holds still under backpressure;
- a new entry only appears after a tick;
- an accepted channel is closed on the following cycle;
- a visit and an accept never touch the table in the same cycle.

Other behaviours need the bench's scenarios: the time-out window measured from the last cell, the choice of first or last pointer by mode, the suppression of time-outs by steady traffic, by a disabled or zero-count channel and by a zero divider, and the delivery of a held entry once the consumer becomes ready.

// File: rtl/rto_pkg.sv
package rto_pkg;
   typedef enum logic {
      MODE_MSG    = 1'b0,
      MODE_STREAM = 1'b1
   } rto_mode_e;

   localparam int STAT_W     = 4;
   localparam int STAT_TO_BIT = 0;
endpackage

// File: rtl/rto_prescaler.sv
module rto_prescaler #(
   parameter int PRE_W = 12
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [PRE_W-1:0] per,
   output logic             tick
);
   logic [PRE_W-1:0] cnt_q;

   assign tick = (per != '0) && (cnt_q >= per - 1'b1);

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt_q <= '0;
      end else if (per == '0 || tick) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   // R1: with a divider above one, ticks are never back to back
   assert_tick_spacing_R1: assert property (@(posedge clk) disable iff (rst)
      (tick && per > 1 && $stable(per)) |=> !tick)
      else $error("prescaler ticked on consecutive cycles");
endmodule

// File: rtl/rto_scan_ptr.sv
module rto_scan_ptr #(
   parameter int NUM_CH = 8,
   parameter int SCAN_W = 6,
   parameter int CH_W   = 3
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              tick,
   input  logic              stall,
   input  logic [SCAN_W-1:0] scan_len,
   output logic              visit_vld,
   output logic [CH_W-1:0]   visit_idx
);
   localparam logic [SCAN_W:0] NCH_EXT = (SCAN_W+1)'(NUM_CH);

   logic [SCAN_W-1:0] ptr_q;
   logic              step;

   assign step      = tick && !stall && (scan_len != '0);
   assign visit_vld = step && ({1'b0, ptr_q} < NCH_EXT);
   assign visit_idx = ptr_q[CH_W-1:0];

   always_ff @(posedge clk) begin
      if (rst) begin
         ptr_q <= '0;
      end else if (step) begin
         ptr_q <= (ptr_q >= scan_len - 1'b1) ? '0 : ptr_q + 1'b1;
      end
   end

   // R6: the scan position is frozen while an entry waits
   assert_scan_frozen_R6: assert property (@(posedge clk) disable iff (rst)
      stall |=> $stable(ptr_q))
      else $error("scan moved while stalled");
endmodule

// File: rtl/rto_chan_table.sv
module rto_chan_table
   import rto_pkg::*;
#(
   parameter int NUM_CH = 8,
   parameter int CH_W   = 3,
   parameter int TERM_W = 6,
   parameter int PTR_W  = 16
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              cfg_we,
   input  logic [CH_W-1:0]   cfg_idx,
   input  logic              cfg_en,
   input  logic              cfg_mode,
   input  logic [TERM_W-1:0] cfg_term,
   input  logic              cell_vld,
   input  logic [CH_W-1:0]   cell_idx,
   input  logic [PTR_W-1:0]  cell_ptr,
   input  logic              visit_vld,
   input  logic [CH_W-1:0]   visit_idx,
   input  logic              clr_vld,
   input  logic [CH_W-1:0]   clr_idx,
   output logic              hit,
   output logic [PTR_W-1:0]  hit_ptr,
   input  logic [CH_W-1:0]   rd_idx,
   output logic              rd_en,
   output logic              rd_mode,
   output logic [TERM_W-1:0] rd_term,
   output logic              rd_open,
   output logic [TERM_W-1:0] rd_idle,
   output logic [PTR_W-1:0]  rd_first,
   output logic [PTR_W-1:0]  rd_last
);
   localparam logic [TERM_W-1:0] IDLE_MAX = {TERM_W{1'b1}};

   logic [NUM_CH-1:0] en_q;
   logic [NUM_CH-1:0] open_q;
   rto_mode_e         mode_q  [NUM_CH];
   logic [TERM_W-1:0] term_q  [NUM_CH];
   logic [TERM_W-1:0] idle_q  [NUM_CH];
   logic [PTR_W-1:0]  first_q [NUM_CH];
   logic [PTR_W-1:0]  last_q  [NUM_CH];

   logic              v_live;
   logic [TERM_W-1:0] v_inc;
   logic [TERM_W-1:0] v_idle;
   logic [TERM_W-1:0] v_term;

   assign v_idle = idle_q[visit_idx];
   assign v_term = term_q[visit_idx];
   assign v_inc  = (v_idle == IDLE_MAX) ? IDLE_MAX : v_idle + 1'b1;
   assign v_live = visit_vld && en_q[visit_idx] && open_q[visit_idx]
                   && (v_term != '0)
                   && !(cell_vld && cell_idx == visit_idx)
                   && !(cfg_we && cfg_idx == visit_idx);
   assign hit     = v_live && (v_inc >= v_term);
   assign hit_ptr = (mode_q[visit_idx] == MODE_STREAM) ? last_q[visit_idx]
                                                       : first_q[visit_idx];

   assign rd_en    = en_q[rd_idx];
   assign rd_mode  = mode_q[rd_idx];
   assign rd_term  = term_q[rd_idx];
   assign rd_open  = open_q[rd_idx];
   assign rd_idle  = idle_q[rd_idx];
   assign rd_first = first_q[rd_idx];
   assign rd_last  = last_q[rd_idx];

   for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      logic sel_cfg, sel_cell, sel_clr, sel_vis;
      assign sel_cfg  = cfg_we   && (cfg_idx   == CH_W'(i));
      assign sel_cell = cell_vld && (cell_idx  == CH_W'(i));
      assign sel_clr  = clr_vld  && (clr_idx   == CH_W'(i));
      assign sel_vis  = v_live   && (visit_idx == CH_W'(i));

      always_ff @(posedge clk) begin
         if (rst) begin
            en_q[i]    <= 1'b0;
            open_q[i]  <= 1'b0;
            mode_q[i]  <= MODE_MSG;
            term_q[i]  <= '0;
            idle_q[i]  <= '0;
            first_q[i] <= '0;
            last_q[i]  <= '0;
         end else if (sel_cfg) begin
            en_q[i]    <= cfg_en;
            mode_q[i]  <= rto_mode_e'(cfg_mode);
            term_q[i]  <= cfg_term;
            open_q[i]  <= 1'b0;
            idle_q[i]  <= '0;
            first_q[i] <= '0;
            last_q[i]  <= '0;
         end else if (sel_cell) begin
            idle_q[i] <= '0;
            open_q[i] <= 1'b1;
            last_q[i] <= cell_ptr;
            if (!open_q[i] || sel_clr) begin
               first_q[i] <= cell_ptr;
            end
         end else if (sel_clr) begin
            open_q[i] <= 1'b0;
            idle_q[i] <= '0;
         end else if (sel_vis) begin
            idle_q[i] <= v_inc;
         end
      end

      // R7: an accepted channel is closed with a zero idle count
      assert_closed_after_accept_R7: assert property (@(posedge clk) disable iff (rst)
         (sel_clr && !sel_cell && !sel_cfg) |=> (!open_q[i] && idle_q[i] == '0))
         else $error("channel not re-initialised after accept");

      // R3: the idle count saturates instead of wrapping
      assert_idle_saturates_R3: assert property (@(posedge clk) disable iff (rst)
         (idle_q[i] == IDLE_MAX) |=> (idle_q[i] == IDLE_MAX || idle_q[i] == '0))
         else $error("idle count wrapped");
   end

   // R6: a visit never coincides with an accept clear
   assert_no_visit_on_accept_R6: assert property (@(posedge clk) disable iff (rst)
      !(visit_vld && clr_vld))
      else $error("scan visited while an entry was being accepted");
endmodule

// File: rtl/rto_scanner.sv
module rto_scanner
   import rto_pkg::*;
#(
   parameter int NUM_CH = 8,
   parameter int PRE_W  = 12,
   parameter int SCAN_W = 6,
   parameter int TERM_W = 6,
   parameter int PTR_W  = 16,
   localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [PRE_W-1:0]  pre_per,
   input  logic [SCAN_W-1:0] scan_len,
   input  logic              cfg_we,
   input  logic [CH_W-1:0]   cfg_idx,
   input  logic              cfg_en,
   input  logic              cfg_mode,
   input  logic [TERM_W-1:0] cfg_term,
   input  logic [CH_W-1:0]   rd_idx,
   output logic              rd_en,
   output logic              rd_mode,
   output logic [TERM_W-1:0] rd_term,
   output logic              rd_open,
   output logic [TERM_W-1:0] rd_idle,
   output logic [PTR_W-1:0]  rd_first,
   output logic [PTR_W-1:0]  rd_last,
   input  logic              cell_vld,
   input  logic [CH_W-1:0]   cell_idx,
   input  logic [PTR_W-1:0]  cell_ptr,
   output logic              stat_vld,
   input  logic              stat_ready,
   output logic [STAT_W-1:0] stat_code,
   output logic [CH_W-1:0]   stat_idx,
   output logic [PTR_W-1:0]  stat_ptr
);
   if (NUM_CH < 2 || NUM_CH >= (1 << SCAN_W)) begin : g_bad_ch
      $error("NUM_CH must be at least 2 and below 2**SCAN_W");
   end
   if (TERM_W < 2 || PRE_W < 1 || PTR_W < 1) begin : g_bad_w
      $error("field widths too small");
   end

   logic             tick;
   logic             visit_vld;
   logic [CH_W-1:0]  visit_idx;
   logic             hit;
   logic [PTR_W-1:0] hit_ptr;
   logic             accept;

   assign accept = stat_vld && stat_ready;

   rto_prescaler #(.PRE_W(PRE_W)) u_pre (
      .clk(clk), .rst(rst), .per(pre_per), .tick(tick)
   );

   rto_scan_ptr #(.NUM_CH(NUM_CH), .SCAN_W(SCAN_W), .CH_W(CH_W)) u_scan (
      .clk(clk), .rst(rst), .tick(tick), .stall(stat_vld),
      .scan_len(scan_len), .visit_vld(visit_vld), .visit_idx(visit_idx)
   );

   rto_chan_table #(.NUM_CH(NUM_CH), .CH_W(CH_W), .TERM_W(TERM_W),
                    .PTR_W(PTR_W)) u_tab (
      .clk(clk), .rst(rst),
      .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_en(cfg_en),
      .cfg_mode(cfg_mode), .cfg_term(cfg_term),
      .cell_vld(cell_vld), .cell_idx(cell_idx), .cell_ptr(cell_ptr),
      .visit_vld(visit_vld), .visit_idx(visit_idx),
      .clr_vld(accept), .clr_idx(stat_idx),
      .hit(hit), .hit_ptr(hit_ptr),
      .rd_idx(rd_idx), .rd_en(rd_en), .rd_mode(rd_mode), .rd_term(rd_term),
      .rd_open(rd_open), .rd_idle(rd_idle), .rd_first(rd_first),
      .rd_last(rd_last)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         stat_vld  <= 1'b0;
         stat_code <= '0;
         stat_idx  <= '0;
         stat_ptr  <= '0;
      end else if (hit) begin
         stat_vld               <= 1'b1;
         stat_code              <= '0;
         stat_code[STAT_TO_BIT] <= 1'b1;
         stat_idx               <= visit_idx;
         stat_ptr               <= hit_ptr;
      end else if (accept) begin
         stat_vld <= 1'b0;
      end
   end

   // R6: a waiting entry holds still under backpressure
   assert_entry_held_R6: assert property (@(posedge clk) disable iff (rst)
      (stat_vld && !stat_ready) |=>
         (stat_vld && $stable(stat_idx) && $stable(stat_ptr) && $stable(stat_code)))
      else $error("entry changed or dropped while not accepted");

   // R2: an entry is only raised by a scan tick
   assert_entry_from_tick_R2: assert property (@(posedge clk) disable iff (rst)
      $rose(stat_vld) |-> $past(tick))
      else $error("entry raised without a tick");
endmodule

// File: tb/rto_scanner_tb.sv
module rto_scanner_tb;
   localparam int NUM_CH = 8;
   localparam int PRE_W  = 12;
   localparam int SCAN_W = 6;
   localparam int TERM_W = 6;
   localparam int PTR_W  = 16;
   localparam int CH_W   = 3;
   localparam int P      = 3;
   localparam int S      = 8;

   logic              clk = 1'b0;
   logic              rst = 1'b1;
   logic [PRE_W-1:0]  pre_per = PRE_W'(P);
   logic [SCAN_W-1:0] scan_len = SCAN_W'(S);
   logic              cfg_we = 1'b0;
   logic [CH_W-1:0]   cfg_idx = '0;
   logic              cfg_en = 1'b0;
   logic              cfg_mode = 1'b0;
   logic [TERM_W-1:0] cfg_term = '0;
   logic [CH_W-1:0]   rd_idx = '0;
   logic              rd_en, rd_mode, rd_open;
   logic [TERM_W-1:0] rd_term, rd_idle;
   logic [PTR_W-1:0]  rd_first, rd_last;
   logic              cell_vld = 1'b0;
   logic [CH_W-1:0]   cell_idx = '0;
   logic [PTR_W-1:0]  cell_ptr = '0;
   logic              stat_vld;
   logic              stat_ready = 1'b1;
   logic [3:0]        stat_code;
   logic [CH_W-1:0]   stat_idx;
   logic [PTR_W-1:0]  stat_ptr;

   rto_scanner #(.NUM_CH(NUM_CH), .PRE_W(PRE_W), .SCAN_W(SCAN_W),
                 .TERM_W(TERM_W), .PTR_W(PTR_W)) u_dut (
      .clk(clk), .rst(rst), .pre_per(pre_per), .scan_len(scan_len),
      .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_en(cfg_en),
      .cfg_mode(cfg_mode), .cfg_term(cfg_term),
      .rd_idx(rd_idx), .rd_en(rd_en), .rd_mode(rd_mode), .rd_term(rd_term),
      .rd_open(rd_open), .rd_idle(rd_idle), .rd_first(rd_first),
      .rd_last(rd_last),
      .cell_vld(cell_vld), .cell_idx(cell_idx), .cell_ptr(cell_ptr),
      .stat_vld(stat_vld), .stat_ready(stat_ready), .stat_code(stat_code),
      .stat_idx(stat_idx), .stat_ptr(stat_ptr)
   );

   always #10 clk = ~clk;

   int cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   typedef struct {
      int idx;
      int ptr;
      int lo;
      int hi;
   } exp_t;

   exp_t q[$];
   int   errors = 0;
   int   checks = 0;
   int   last_t = 0;

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", errors, checks);
   endtask

   // monitor: pops the scoreboard on every accepted entry
   initial begin
      forever begin
         @(negedge clk);
         #1;
         if (stat_vld && stat_ready) begin
            if (q.size() == 0) begin
               chk(1'b0, "R4", "unexpected entry on channel", stat_idx, 'hff);
            end else begin
               exp_t e;
               e = q.pop_front();
               chk(stat_idx == CH_W'(e.idx), "R5", "entry channel", stat_idx, e.idx);
               chk(stat_ptr == PTR_W'(e.ptr), "R5", "entry pointer", stat_ptr, e.ptr);
               chk(stat_code == 4'b0001, "R5", "status code", stat_code, 1);
               chk(cyc >= e.lo && cyc <= e.hi, "R2", "time-out cycle", cyc, e.lo);
            end
         end
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      chk(1'b0, "R6", "watchdog expired", cyc, 0);
      summary();
      $finish;
   end

   task automatic cfg_wr(input int idx, input bit en, input bit mode, input int term);
      @(negedge clk);
      cfg_we = 1'b1; cfg_idx = CH_W'(idx); cfg_en = en;
      cfg_mode = mode; cfg_term = TERM_W'(term);
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic send_cell(input int idx, input int ptr);
      @(negedge clk);
      cell_vld = 1'b1; cell_idx = CH_W'(idx); cell_ptr = PTR_W'(ptr);
      last_t = cyc;
      @(negedge clk);
      cell_vld = 1'b0;
   endtask

   task automatic rd(input int idx);
      @(negedge clk);
      rd_idx = CH_W'(idx);
      #1;
   endtask

   task automatic expect_to(input int idx, input int ptr, input int t0,
                            input int term, input bit strict);
      exp_t e;
      e.idx = idx;
      e.ptr = ptr;
      e.lo  = strict ? t0 + (term - 1) * P * S : 0;
      e.hi  = strict ? t0 + term * P * S + 6 : t0 + 100000;
      q.push_back(e);
   endtask

   task automatic wait_empty(input int maxc, input string req);
      for (int k = 0; k < maxc && q.size() != 0; k++) @(negedge clk);
      repeat (3) @(negedge clk);
      chk(q.size() == 0, req, "pending expected entries", q.size(), 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst = 1'b0;

      // R9: reset state
      rd(0);
      chk(stat_vld == 1'b0, "R9", "stat_vld after reset", stat_vld, 0);
      chk({rd_en, rd_open, rd_mode} == 3'b000, "R9", "flags after reset",
          {rd_en, rd_open, rd_mode}, 0);
      chk(rd_term == 0 && rd_idle == 0 && rd_first == 0, "R9", "fields after reset",
          rd_term, 0);

      // R8: table write and read back
      cfg_wr(2, 1'b1, 1'b1, 4);
      rd(2);
      chk(rd_en && rd_mode && rd_term == 4, "R8", "written fields",
          {rd_en, rd_mode, rd_term}, {1'b1, 1'b1, 6'd4});
      chk(!rd_open && rd_idle == 0, "R8", "open/idle after write", rd_open, 0);

      // R5 message mode: first pointer reported
      cfg_wr(1, 1'b1, 1'b0, 4);
      send_cell(1, 'h100);
      send_cell(1, 'h104);
      send_cell(1, 'h108);
      rd(1);
      chk(rd_first == 'h100 && rd_last == 'h108, "R3", "pointers recorded",
          rd_first, 'h100);
      expect_to(1, 'h100, last_t, 4, 1'b1);
      wait_empty(400, "R2");

      // R7: channel closed after accept, next cell opens a new packet
      rd(1);
      chk(!rd_open && rd_idle == 0, "R7", "closed after accept", {rd_open, rd_idle}, 0);
      send_cell(1, 'h180);
      rd(1);
      chk(rd_open && rd_first == 'h180, "R7", "new packet first pointer", rd_first, 'h180);
      cfg_wr(1, 1'b0, 1'b0, 4);

      // R5 streaming mode: last pointer reported
      send_cell(2, 'h200);
      send_cell(2, 'h204);
      send_cell(2, 'h208);
      expect_to(2, 'h208, last_t, 4, 1'b1);
      wait_empty(400, "R5");
      cfg_wr(2, 1'b0, 1'b0, 4);

      // R6: backpressure holds the entry and freezes the scan
      @(negedge clk);
      stat_ready = 1'b0;
      cfg_wr(6, 1'b1, 1'b0, 3);
      cfg_wr(7, 1'b1, 1'b1, 3);
      send_cell(6, 'h600);
      send_cell(6, 'h604);
      expect_to(6, 'h600, last_t, 3, 1'b0);
      for (int k = 0; k < 400 && !stat_vld; k++) @(negedge clk);
      send_cell(7, 'h700);
      for (int k = 0; k < 3; k++) begin
         repeat (40) @(negedge clk);
         #1;
         chk(stat_vld && stat_idx == 6 && stat_ptr == 'h600, "R6", "held entry",
             {stat_vld, stat_ptr}, {1'b1, 16'h600});
      end
      rd(7);
      chk(rd_open && rd_idle == 0, "R6", "no scan while stalled", rd_idle, 0);
      expect_to(7, 'h700, cyc, 3, 1'b0);
      @(negedge clk);
      stat_ready = 1'b1;
      wait_empty(400, "R6");
      cfg_wr(6, 1'b0, 1'b0, 0);
      cfg_wr(7, 1'b0, 1'b0, 0);

      // R3: steady traffic keeps a channel from timing out
      cfg_wr(3, 1'b1, 1'b0, 4);
      for (int k = 0; k < 10; k++) begin
         send_cell(3, 'h300 + 4 * k);
         repeat (48) @(negedge clk);
      end
      rd(3);
      chk(!stat_vld, "R3", "no entry under steady traffic", stat_vld, 0);
      chk(rd_open && rd_first == 'h300 && rd_last == 'h324, "R3", "open packet pointers",
          rd_last, 'h324);
      chk(rd_idle < 4, "R3", "idle count below terminal", rd_idle, 3);
      cfg_wr(3, 1'b0, 1'b0, 0);

      // R4: disabled, zero-count and closed channels are skipped
      cfg_wr(4, 1'b0, 1'b0, 4);
      cfg_wr(5, 1'b1, 1'b0, 0);
      cfg_wr(0, 1'b1, 1'b0, 2);
      send_cell(4, 'h400);
      send_cell(5, 'h500);
      repeat (400) @(negedge clk);
      #1;
      chk(!stat_vld, "R4", "no entry from skipped channels", stat_vld, 0);
      rd(4);
      chk(rd_open && rd_idle == 0, "R4", "disabled channel idle", rd_idle, 0);
      rd(5);
      chk(rd_open && rd_idle == 0, "R4", "zero-count channel idle", rd_idle, 0);
      rd(0);
      chk(!rd_open && rd_idle == 0, "R4", "closed channel idle", rd_idle, 0);
      cfg_wr(4, 1'b0, 1'b0, 0);
      cfg_wr(5, 1'b0, 1'b0, 0);
      cfg_wr(0, 1'b0, 1'b0, 0);

      // R1: zero divider stops the scan; restoring it resumes
      @(negedge clk);
      pre_per = '0;
      cfg_wr(1, 1'b1, 1'b0, 2);
      send_cell(1, 'h150);
      repeat (300) @(negedge clk);
      rd(1);
      chk(!stat_vld && rd_idle == 0, "R1", "no progress with zero divider",
          {stat_vld, rd_idle}, 0);
      @(negedge clk);
      pre_per = PRE_W'(P);
      expect_to(1, 'h150, cyc, 2, 1'b1);
      wait_empty(400, "R1");

      repeat (5) @(negedge clk);
      summary();
      $finish;
   end
endmodule